// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block watches processor writes into the lower, bank-switched program window of a cartridge that holds a byte-wide parallel flash. It also watches the current bank number. From these writes it picks out the standard unlock-and-command sequences of such a flash. It turns each completed command into a single-cycle action pulse towards a memory back end. The actions are: erase one 4 KB sector, erase the whole chip, and program one byte. Each pulse carries the address, bank and data of the write that triggered it. The back end owns the storage array. It applies the programming rule itself: the new byte is the old byte ANDed with the written data.

An unlock step matches only when the full processor address, the data and the bank register all match. So the same address in two different banks counts as two different flash locations.

The block also has a device-identification mode, and a read-data override that is valid while that mode is on. The identification codes depend on a size selector for 128 KB, 256 KB or 512 KB devices.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and after its release until the first write, no action pulse is high and `id_active` is 0.
- R2: The five writes (address, data, bank) = ($9555,$AA,1), ($AAAA,$55,0), ($9555,$80,1), ($9555,$AA,1), ($AAAA,$55,0) select erase mode. If the next write carries data $30, `erase_sector` is high for exactly the one cycle after that write's clock edge. In that cycle `act_addr` and `act_bank` hold that write's address and bank.
- R3: In erase mode, a write with data $10 gives the same one-cycle `erase_chip` pulse. A write with any other data gives no pulse. After any write in erase mode, the decoder is idle again.
- R4: After the first two unlock writes, a write of ($9555,$A0,1) selects program mode. The next write gives a one-cycle `prog_byte` pulse, with that write's address, bank and data on `act_addr`, `act_bank` and `act_data`. The decoder is then idle.
- R5: After the first two unlock writes, a write of ($9555,$90,1) sets `id_active` from the next cycle on. It returns the sequence to idle.
- R6: A write that does not match the expected step returns the sequence to idle. That write is not taken as the first step of a new sequence.
- R7: A mismatching write with data $F0 clears `id_active`. A mismatching write with any other data leaves it unchanged.
- R8: While `id_active` is 1, `id_data` is $BF when `rd_odd` is 0. When `rd_odd` is 1, `id_data` is $B5 for `size_sel`=0 (128 KB), $B6 for 1 (256 KB), and $B7 for 2 or 3 (512 KB). While `id_active` is 0, `id_data` is $00.
- R9: The decoder ignores its write inputs while `wr_en` is low. At most one action pulse is high in any cycle, and no pulse lasts more than one cycle.
- R10: An unlock step whose bank differs from the bank listed for it in R2 is a mismatch, even when its address and data match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the lower program window, one cycle per write |
| wr_addr | input | 16 | Processor address of the write |
| wr_data | input | 8 | Data of the write |
| bank | input | 5 | Current bank register value |
| size_sel | input | 2 | Device size: 0 = 128 KB, 1 = 256 KB, 2/3 = 512 KB |
| rd_odd | input | 1 | Lowest bit of the current read address |
| id_active | output | 1 | Identification mode on; `id_data` overrides read data |
| id_data | output | 8 | Identification byte for the current read |
| erase_sector | output | 1 | One-cycle sector-erase pulse |
| erase_chip | output | 1 | One-cycle chip-erase pulse |
| prog_byte | output | 1 | One-cycle byte-program pulse |
| act_addr | output | 16 | Address belonging to the action pulse |
| act_bank | output | 5 | Bank belonging to the action pulse |
| act_data | output | 8 | Data belonging to the action pulse |

## Verification
A wrong internal sequence state shows up at the latest one write after the sequence should have completed. Either an action pulse is missing, or a pulse appears where none is due. That pulse is visible in the cycle right after the offending write's edge. The sweeps over every erase data byte and every bank value at the bank-qualified steps expose a step register that accepts too much or too little. A stuck or wrongly set identification flag is visible at once on `id_active` and `id_data`, in the cycle after the write that should have changed it.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_U1    = 3'd1,
    ST_U2    = 3'd2,
    ST_U3    = 3'd3,
    ST_U4    = 3'd4,
    ST_ERASE = 3'd5,
    ST_PROG  = 3'd6
  } seq_t;

  localparam logic [15:0] ADR_LO = 16'h9555;
  localparam logic [15:0] ADR_HI = 16'hAAAA;

  localparam logic [7:0] D_KEY1 = 8'hAA;
  localparam logic [7:0] D_KEY2 = 8'h55;
  localparam logic [7:0] D_ERS  = 8'h80;
  localparam logic [7:0] D_PRG  = 8'hA0;
  localparam logic [7:0] D_IDON = 8'h90;
  localparam logic [7:0] D_RST  = 8'hF0;
  localparam logic [7:0] D_SEC  = 8'h30;
  localparam logic [7:0] D_CHIP = 8'h10;
  localparam logic [7:0] ID_MFR = 8'hBF;

  // expected write for each unlock step; the step index is the state
  function automatic logic [15:0] step_addr(input seq_t s);
    case (s)
      ST_U1, ST_U4: step_addr = ADR_HI;
      default:      step_addr = ADR_LO;
    endcase
  endfunction

  function automatic logic [7:0] step_data(input seq_t s);
    case (s)
      ST_U1, ST_U4: step_data = D_KEY2;
      ST_U2:        step_data = D_ERS;
      default:      step_data = D_KEY1;
    endcase
  endfunction

  function automatic logic step_bank(input seq_t s);
    case (s)
      ST_U1, ST_U4: step_bank = 1'b0;
      default:      step_bank = 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] id_code(input logic [1:0] sz);
    case (sz)
      2'd0:    id_code = 8'hB5;
      2'd1:    id_code = 8'hB6;
      default: id_code = 8'hB7;
    endcase
  endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BANK_W-1:0] bank,
  output logic              go_sector,
  output logic              go_chip,
  output logic              go_prog,
  output logic              id_set,
  output logic              id_clr
);

  seq_t st, st_nxt;
  logic step_hit, at_cmd;

  always_comb begin
    step_hit = (wr_addr == ADDR_W'(step_addr(st))) &&
               (wr_data == step_data(st)) &&
               (bank == BANK_W'(step_bank(st)));
    at_cmd   = (st == ST_U2) && (wr_addr == ADDR_W'(ADR_LO)) &&
               (bank == BANK_W'(1'b1));
  end

  always_comb begin
    st_nxt    = ST_IDLE;
    go_sector = 1'b0;
    go_chip   = 1'b0;
    go_prog   = 1'b0;
    id_set    = 1'b0;
    id_clr    = 1'b0;
    case (st)
      ST_ERASE: begin
        go_sector = wr_en && (wr_data == D_SEC);
        go_chip   = wr_en && (wr_data == D_CHIP);
      end
      ST_PROG: go_prog = wr_en;
      default: begin
        if (step_hit) begin
          st_nxt = (st == ST_U4) ? ST_ERASE : seq_t'(st + 3'd1);
        end else if (at_cmd && (wr_data == D_PRG)) begin
          st_nxt = ST_PROG;
        end else if (at_cmd && (wr_data == D_IDON)) begin
          id_set = wr_en;
        end else begin
          id_clr = wr_en && (wr_data == D_RST);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else if (wr_en) begin
      st <= st_nxt;
    end
  end

  // R3 R4: any write in an action mode brings the sequence back to idle
  assert_action_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (st == ST_ERASE || st == ST_PROG)) |=> (st == ST_IDLE));

  // R4: program mode is only entered from the third step with the program command
  assert_prog_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_PROG) |-> $past(st == ST_U2 && wr_en && wr_data == D_PRG));

  // R9: no write, no state change
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(st));

endmodule

// File: rtl/fcd_id.sv
module fcd_id
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_set,
  input  logic              id_clr,
  input  logic [1:0]        size_sel,
  input  logic              rd_odd,
  output logic              id_active,
  output logic [DATA_W-1:0] id_data
);

  logic id_q, id_nxt, id_ce;

  always_comb begin
    id_ce  = id_set || id_clr;
    id_nxt = id_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= 1'b0;
    end else if (id_ce) begin
      id_q <= id_nxt;
    end
  end

  always_comb begin
    id_active = id_q;
    if (!id_q)      id_data = '0;
    else if (rd_odd) id_data = id_code(size_sel);
    else            id_data = ID_MFR;
  end

  // R5 R7: set and clear requests never coincide
  assert_id_req_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_set && id_clr));

endmodule

// File: rtl/fcd_act.sv
module fcd_act
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_sector,
  input  logic              go_chip,
  input  logic              go_prog,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BANK_W-1:0] bank,
  output logic              erase_sector,
  output logic              erase_chip,
  output logic              prog_byte,
  output logic [ADDR_W-1:0] act_addr,
  output logic [BANK_W-1:0] act_bank,
  output logic [DATA_W-1:0] act_data
);

  logic load;

  always_comb load = go_sector || go_chip || go_prog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_sector <= 1'b0;
      erase_chip   <= 1'b0;
      prog_byte    <= 1'b0;
    end else begin
      erase_sector <= go_sector;
      erase_chip   <= go_chip;
      prog_byte    <= go_prog;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_addr <= '0;
      act_bank <= '0;
      act_data <= '0;
    end else if (load) begin
      act_addr <= wr_addr;
      act_bank <= bank;
      act_data <= wr_data;
    end
  end

  // R9: at most one action at a time
  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_sector, erase_chip, prog_byte}));

  // R9: every action lasts one cycle
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_sector || erase_chip || prog_byte) |=> !(erase_sector || erase_chip || prog_byte));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [BANK_W-1:0] bank,
  input  logic [1:0]        size_sel,
  input  logic              rd_odd,
  output logic              id_active,
  output logic [7:0]        id_data,
  output logic              erase_sector,
  output logic              erase_chip,
  output logic              prog_byte,
  output logic [ADDR_W-1:0] act_addr,
  output logic [BANK_W-1:0] act_bank,
  output logic [7:0]        act_data
);

  logic go_sector, go_chip, go_prog, id_set, id_clr;

  fcd_seq #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bank(bank), .go_sector(go_sector),
    .go_chip(go_chip), .go_prog(go_prog), .id_set(id_set), .id_clr(id_clr)
  );

  fcd_id u_id (
    .clk(clk), .rst_n(rst_n), .id_set(id_set), .id_clr(id_clr),
    .size_sel(size_sel), .rd_odd(rd_odd), .id_active(id_active),
    .id_data(id_data)
  );

  fcd_act #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_act (
    .clk(clk), .rst_n(rst_n), .go_sector(go_sector), .go_chip(go_chip),
    .go_prog(go_prog), .wr_addr(wr_addr), .wr_data(wr_data), .bank(bank),
    .erase_sector(erase_sector), .erase_chip(erase_chip),
    .prog_byte(prog_byte), .act_addr(act_addr), .act_bank(act_bank),
    .act_data(act_data)
  );

  // R2: an action only follows a write edge
  assert_pulse_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_sector || erase_chip || prog_byte) |-> $past(wr_en));

  // R5: identification mode only turns on after its command byte
  assert_id_on_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_active) |-> $past(wr_en && wr_data == D_IDON));

  // R7: identification mode only turns off on the reset byte
  assert_id_off_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_active) |-> $past(wr_en && wr_data == D_RST));

endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [4:0]  bank;
  logic [1:0]  size_sel;
  logic        rd_odd;
  logic        id_active;
  logic [7:0]  id_data;
  logic        erase_sector, erase_chip, prog_byte;
  logic [15:0] act_addr;
  logic [4:0]  act_bank;
  logic [7:0]  act_data;

  always #4 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bank(bank), .size_sel(size_sel), .rd_odd(rd_odd),
    .id_active(id_active), .id_data(id_data), .erase_sector(erase_sector),
    .erase_chip(erase_chip), .prog_byte(prog_byte), .act_addr(act_addr),
    .act_bank(act_bank), .act_data(act_data)
  );

  int total = 0;
  int bad = 0;
  logic        c_sec, c_chip, c_prog, c_id;
  logic [15:0] c_addr;
  logic [4:0]  c_bank;
  logic [7:0]  c_data;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one write: inputs set at a falling edge, outputs captured at the next one
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [4:0] b);
    wr_addr = a; wr_data = d; bank = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en  = 1'b0;
    c_sec  = erase_sector; c_chip = erase_chip; c_prog = prog_byte;
    c_id   = id_active;    c_addr = act_addr;   c_bank = act_bank;
    c_data = act_data;
  endtask

  task automatic unlock2();
    wr(16'h9555, 8'hAA, 5'd1);
    wr(16'hAAAA, 8'h55, 5'd0);
  endtask

  task automatic unlock5();
    unlock2();
    wr(16'h9555, 8'h80, 5'd1);
    wr(16'h9555, 8'hAA, 5'd1);
    wr(16'hAAAA, 8'h55, 5'd0);
  endtask

  function automatic logic [7:0] exp_id(input logic odd, input logic [1:0] s);
    if (!odd) return 8'hBF;
    return (s == 2'd0) ? 8'hB5 : (s == 2'd1) ? 8'hB6 : 8'hB7;
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; bank = '0;
    size_sel = 2'd2; rd_odd = 1'b0;
    repeat (3) @(negedge clk);
    chk(!erase_sector && !erase_chip && !prog_byte, "R1 pulses in reset", 1, 0);
    chk(id_active == 1'b0, "R1 id in reset", id_active, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({erase_sector, erase_chip, prog_byte, id_active} == 4'b0, "R1 after release",
        {erase_sector, erase_chip, prog_byte, id_active}, 0);

    // R2 R3: sweep every data byte in erase mode
    for (int d = 0; d < 256; d++) begin
      logic [15:0] a;
      a = 16'h8000 + 16'(d) * 16'd57;
      unlock5();
      wr(a, 8'(d), 5'(d));
      chk(c_sec == (d == 8'h30), "R2 sector pulse", c_sec, d == 8'h30);
      chk(c_chip == (d == 8'h10), "R3 chip pulse", c_chip, d == 8'h10);
      chk(c_prog == 1'b0, "R3 no program pulse", c_prog, 0);
      if (d == 8'h30) begin
        chk(c_addr == a, "R2 sector address", c_addr, a);
        chk(c_bank == 5'(d), "R2 sector bank", c_bank, d);
      end
      wr(16'h9000, 8'h30, 5'd1);
      chk(!c_sec && !c_chip, "R3 idle after erase command, R9 single cycle",
          {c_sec, c_chip}, 0);
    end

    // R4: byte program with several payloads
    for (int d = 0; d < 256; d += 17) begin
      logic [15:0] a;
      a = 16'h8000 + 16'(d) * 16'd13;
      unlock2();
      wr(16'h9555, 8'hA0, 5'd1);
      chk(!c_prog, "R4 no pulse on command", c_prog, 0);
      wr(a, 8'(d), 5'(d % 32));
      chk(c_prog && !c_sec && !c_chip, "R4 program pulse", {c_prog, c_sec, c_chip}, 3'b100);
      chk(c_addr == a && c_data == 8'(d) && c_bank == 5'(d % 32), "R4 program payload",
          {c_addr, c_data, c_bank}, {a, 8'(d), 5'(d % 32)});
      wr(a, 8'h30, 5'd1);
      chk(!c_prog && !c_sec, "R4 idle after program, R9 single cycle", {c_prog, c_sec}, 0);
    end

    // R5: identification mode on, R8: read codes
    unlock2();
    wr(16'h9555, 8'h90, 5'd1);
    chk(c_id == 1'b1, "R5 id on", c_id, 1);
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 2; o++) begin
        size_sel = 2'(s); rd_odd = 1'(o);
        #1;
        chk(id_data == exp_id(1'(o), 2'(s)), "R8 id code", id_data, exp_id(1'(o), 2'(s)));
      end
    end
    // R5: sequence back at idle after id command
    wr(16'h9555, 8'h80, 5'd1);
    unlock5();
    wr(16'h9000, 8'h30, 5'd1);
    chk(c_sec == 1'b1, "R5 idle after id command", c_sec, 1);
    // R7: other mismatches keep id, $F0 clears it
    wr(16'h8123, 8'h12, 5'd0);
    chk(c_id == 1'b1, "R7 id kept", c_id, 1);
    wr(16'h8123, 8'hF0, 5'd0);
    chk(c_id == 1'b0, "R7 id cleared", c_id, 0);
    #1;
    chk(id_data == 8'h00, "R8 id data when off", id_data, 0);

    // R6: a mismatching key is not taken as a new first step
    wr(16'h9555, 8'hAA, 5'd1);
    wr(16'h9555, 8'hAA, 5'd1);
    wr(16'hAAAA, 8'h55, 5'd0);
    wr(16'h9555, 8'h80, 5'd1);
    wr(16'h9555, 8'hAA, 5'd1);
    wr(16'hAAAA, 8'h55, 5'd0);
    wr(16'h9000, 8'h30, 5'd1);
    chk(!c_sec, "R6 no restart on mismatch", c_sec, 0);
    // R6: $90 after only one step is no command
    wr(16'h9555, 8'hAA, 5'd1);
    wr(16'h9555, 8'h90, 5'd1);
    chk(!c_id, "R6 id needs two steps", c_id, 0);

    // R10: bank sweep at a bank-1 step and at a bank-0 step
    for (int b = 0; b < 32; b++) begin
      wr(16'h9555, 8'hAA, 5'(b));
      wr(16'hAAAA, 8'h55, 5'd0);
      wr(16'h9555, 8'h80, 5'd1);
      wr(16'h9555, 8'hAA, 5'd1);
      wr(16'hAAAA, 8'h55, 5'd0);
      wr(16'h9000, 8'h30, 5'd0);
      chk(c_sec == (b == 1), "R10 bank at first step", c_sec, b == 1);
      wr(16'h9555, 8'hAA, 5'd1);
      wr(16'hAAAA, 8'h55, 5'(b));
      wr(16'h9555, 8'h80, 5'd1);
      wr(16'h9555, 8'hAA, 5'd1);
      wr(16'hAAAA, 8'h55, 5'd0);
      wr(16'h9000, 8'h30, 5'd0);
      chk(c_sec == (b == 0), "R10 bank at second step", c_sec, b == 0);
    end

    // R9: writes with wr_en low are ignored
    unlock5();
    wr_addr = 16'h9000; wr_data = 8'h30; bank = 5'd1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!erase_sector && !erase_chip, "R9 no pulse without strobe", erase_sector, 0);
    end
    wr(16'h9000, 8'h10, 5'd1);
    chk(c_chip == 1'b1, "R9 erase mode kept while strobe low", c_chip, 1);

    finish_run();
  end

endmodule